// File: doc/BRIEF.md
# Accumulator ALU with Decimal Correction

This block is the 8-bit arithmetic and logic unit of a small accumulator processor. Each cycle it takes an operation code, the accumulator, the X register, an operand byte, and the incoming carry, overflow and decimal flags. One clock edge later it presents a result byte, an X result, and the updated N, V, Z and C flags. The block covers the logical ops, add and subtract with carry, comparisons, shifts and rotates, and bit-test. It also handles three combined immediate operations: an AND whose bit 7 goes to carry, an AND followed by a right shift, and an AND of A with X followed by a subtract into X.

When the decimal flag is set, add and subtract apply nibble correction to the sum, and this correction also covers digits above 9. In decimal add, Z comes from the uncorrected binary sum. N and V are taken before the high-nibble correction. Subtraction is addition of the inverted operand, so a set carry means no borrow. The sequencer does the routing:
- A shift on the accumulator puts A on the operand port.
- A compare against Y puts Y on the accumulator port.

The parameter `DEC_EN` removes the decimal path when it is 0.

Top module: `acc_alu`

## Requirements
- R1: ORA (op 0), AND (op 1), EOR (op 2) and PASS (op 15, result = operand) combine A with the operand. N is result bit 7 and Z is set when the result is zero. C and V copy their inputs, and the decimal flag has no effect.
- R2: With the decimal flag clear, ADC (op 3) returns A + operand + C and SBC (op 4) returns A + ~operand + C. C is the carry out of bit 7 (so for SBC, C=1 means no borrow), V is signed overflow, and N and Z come from the result.
- R3: In decimal ADC, the low nibble sum (including carry) gets +6 and a carry into the high nibble when it is 10 or more. The high part gets +$60 when it reaches $A0. Non-BCD digits follow the same rule: $00+$0F=$15, $05+$1F=$2A, $0F+$0A=$1F, $0F+$0B=$10.
- R4: In decimal ADC, Z comes from the binary sum. N and V come from the value before the high-nibble correction. C is set when the corrected value reaches $100. For example, $80+$80 with C=0 gives $60 with V=1, Z=1, C=1.
- R5: In decimal SBC, the result is BCD-corrected per nibble ($00-$01 with C=1 gives $99). N, V, Z and C are those of the binary subtraction.
- R6: CMP (op 5, uses A) and CPX (op 6, uses X) set N, Z and C from register − operand. The result byte equals A and V is unchanged.
- R7: ASL (op 7), LSR (op 8), ROL (op 9) and ROR (op 10) shift the operand. ROL and ROR feed C into the vacated bit, while ASL and LSR feed in 0. The bit shifted out goes to C, and N and Z come from the result.
- R8: BIT (op 11) sets N to operand bit 7, V to operand bit 6, and Z to (A AND operand)==0. The result byte equals A and C is unchanged.
- R9: ANC (op 12) returns A AND operand with C = result bit 7. ALR (op 13) returns (A AND operand) shifted right by one, with C = bit 0 of the AND. For both, N and Z come from the result and V is unchanged.
- R10: AXS (op 14) sets the X result to (A AND X) − operand and ignores the carry input. N, Z and C are set as a compare sets them, V is unchanged, and the result byte equals A.
- R11: For every op other than AXS, the X result equals the X input.
- R12: All outputs are registered, so inputs applied before a rising edge appear after it and not before. A synchronous active-low reset clears every output to 0.
- R13: With DEC_EN=0, ADC and SBC ignore the decimal flag and always produce the binary result and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator (or Y for a Y compare) |
| xreg_i | input | 8 | X register |
| opnd_i | input | 8 | Operand byte |
| c_i | input | 1 | Carry flag in |
| v_i | input | 1 | Overflow flag in |
| d_i | input | 1 | Decimal mode flag |
| res_o | output | 8 | Result byte |
| xres_o | output | 8 | X result |
| n_o | output | 1 | Negative flag out |
| v_o | output | 1 | Overflow flag out |
| z_o | output | 1 | Zero flag out |
| c_o | output | 1 | Carry flag out |

## Verification
The bench builds two copies of the block from the same stimulus. The copy with `DEC_EN=1` exercises the nibble-correction path, including non-BCD digits, Z taken from the binary sum, and N and V taken from the intermediate value. The copy with `DEC_EN=0` shows that the decimal flag then leaves add and subtract on the plain binary path. The second copy exercises the generate branch that the default build does not elaborate.

// File: rtl/acc_alu_pkg.sv
// Package: shared widths, operation codes and the flag/result bundle for the
// accumulator ALU. Assumes an 8-bit datapath split into two nibbles.
package acc_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    typedef enum logic [3:0] {
        OP_ORA  = 4'd0,
        OP_AND  = 4'd1,
        OP_EOR  = 4'd2,
        OP_ADC  = 4'd3,
        OP_SBC  = 4'd4,
        OP_CMP  = 4'd5,
        OP_CPX  = 4'd6,
        OP_ASL  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_BIT  = 4'd11,
        OP_ANC  = 4'd12,
        OP_ALR  = 4'd13,
        OP_AXS  = 4'd14,
        OP_PASS = 4'd15
    } op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          n;
        logic          v;
        logic          z;
        logic          c;
    } flags_t;
endpackage

// File: rtl/alu_bitops.sv
// Module: logical, shift/rotate, bit-test and combined AND operations.
// Purely combinational. Assumes shifts act on the operand port; ops it does
// not own return A with the incoming flags unchanged.
module alu_bitops
    import acc_alu_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          c_in,
    input  logic          v_in,
    output flags_t        o
);
    logic [DW-1:0] anded;

    assign anded = acc & opnd;

    // Select the result byte and carry for the owned operation.
    always_comb begin
        o.res = acc;
        o.c   = c_in;
        o.v   = v_in;
        case (op)
            OP_ORA:  o.res = acc | opnd;
            OP_AND:  o.res = anded;
            OP_EOR:  o.res = acc ^ opnd;
            OP_PASS: o.res = opnd;
            OP_ASL:  begin o.res = {opnd[DW-2:0], 1'b0}; o.c = opnd[DW-1]; end
            OP_LSR:  begin o.res = {1'b0, opnd[DW-1:1]}; o.c = opnd[0];    end
            OP_ROL:  begin o.res = {opnd[DW-2:0], c_in}; o.c = opnd[DW-1]; end
            OP_ROR:  begin o.res = {c_in, opnd[DW-1:1]}; o.c = opnd[0];    end
            OP_ANC:  begin o.res = anded; o.c = anded[DW-1]; end
            OP_ALR:  begin o.res = {1'b0, anded[DW-1:1]}; o.c = anded[0]; end
            OP_BIT:  begin o.res = acc; o.v = opnd[DW-2]; end
            default: o.res = acc;
        endcase
    end

    // Derive N and Z; bit-test takes them from the operand and the AND.
    always_comb begin
        if (op == OP_BIT) begin
            o.n = opnd[DW-1];
            o.z = (anded == '0);
        end else begin
            o.n = o.res[DW-1];
            o.z = (o.res == '0);
        end
    end
endmodule

// File: rtl/alu_adder.sv
// Module: add/subtract with carry, binary and (optionally) decimal.
// Subtraction adds the inverted operand. When DEC_EN is 0 the decimal
// correction is not built and the decimal flag has no effect.
module alu_adder
    import acc_alu_pkg::*;
#(
    parameter bit DEC_EN = 1'b1
) (
    input  logic          sub,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          c_in,
    input  logic          d_in,
    output flags_t        o
);
    localparam int EW = DW + 2;                 // headroom for corrections
    localparam logic [EW-1:0] TEN    = EW'(10);
    localparam logic [EW-1:0] SIX    = EW'(6);
    localparam logic [EW-1:0] NMASK  = EW'((1 << NW) - 1);
    localparam logic [EW-1:0] NCARRY = EW'(1 << NW);
    localparam logic [EW-1:0] HI_LIM = EW'(10 << NW);
    localparam logic [EW-1:0] HI_ADJ = EW'(6 << NW);

    logic [DW-1:0] b_eff;
    logic [DW:0]   bin_sum;
    logic          bin_v;
    logic [DW-1:0] dadd_res, dsub_res;
    logic          dadd_n, dadd_v, dadd_c;
    logic          use_dec;

    assign b_eff   = sub ? ~opnd : opnd;
    assign bin_sum = {1'b0, acc} + {1'b0, b_eff} + {{DW{1'b0}}, c_in};
    assign bin_v   = ~(acc[DW-1] ^ b_eff[DW-1]) & (acc[DW-1] ^ bin_sum[DW-1]);
    assign use_dec = d_in & DEC_EN;

    generate
        if (DEC_EN) begin : g_dec
            logic [EW-1:0] lo, lo_f, hi, hi_f;
            logic [EW-1:0] slo, slo_f, shi, shi_f;
            logic          dec_unused;

            // Decimal add: correct low nibble, take N/V, then correct high part.
            always_comb begin
                lo   = EW'(acc[NW-1:0]) + EW'(opnd[NW-1:0]) + EW'(c_in);
                lo_f = (lo >= TEN) ? (((lo + SIX) & NMASK) + NCARRY) : lo;
                hi   = EW'({acc[DW-1:NW], {NW{1'b0}}}) + EW'({opnd[DW-1:NW], {NW{1'b0}}}) + lo_f;
                hi_f = (hi >= HI_LIM) ? (hi + HI_ADJ) : hi;
            end
            assign dadd_n   = hi[DW-1];
            assign dadd_v   = ~(acc[DW-1] ^ opnd[DW-1]) & (acc[DW-1] ^ hi[DW-1]);
            assign dadd_c   = (hi_f[EW-1:DW] != '0);
            assign dadd_res = hi_f[DW-1:0];

            // Decimal subtract in two's complement; a set top bit means negative.
            always_comb begin
                slo   = EW'(acc[NW-1:0]) - EW'(opnd[NW-1:0]) + EW'(c_in) - EW'(1);
                slo_f = slo[EW-1] ? (((slo - SIX) & NMASK) - NCARRY) : slo;
                shi   = EW'({acc[DW-1:NW], {NW{1'b0}}}) - EW'({opnd[DW-1:NW], {NW{1'b0}}}) + slo_f;
                shi_f = shi[EW-1] ? (shi - HI_ADJ) : shi;
            end
            assign dsub_res   = shi_f[DW-1:0];
            assign dec_unused = ^shi_f[EW-1:DW];
        end else begin : g_bin
            assign dadd_res = bin_sum[DW-1:0];
            assign dsub_res = bin_sum[DW-1:0];
            assign dadd_n   = bin_sum[DW-1];
            assign dadd_v   = bin_v;
            assign dadd_c   = bin_sum[DW];
        end
    endgenerate

    // Choose binary, decimal-add or decimal-subtract outputs.
    always_comb begin
        o.res = bin_sum[DW-1:0];
        o.n   = bin_sum[DW-1];
        o.v   = bin_v;
        o.z   = (bin_sum[DW-1:0] == '0);
        o.c   = bin_sum[DW];
        if (use_dec && !sub) begin
            o.res = dadd_res;
            o.n   = dadd_n;
            o.v   = dadd_v;
            o.c   = dadd_c;
        end else if (use_dec && sub) begin
            o.res = dsub_res;
        end
    end
endmodule

// File: rtl/alu_compare.sv
// Module: register-minus-operand for compares and the A-AND-X subtract.
// Carry in is never used; no_borrow set means the register was >= operand.
module alu_compare
    import acc_alu_pkg::*;
(
    input  logic          use_x,
    input  logic          use_ax,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] xreg,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] diff,
    output logic          no_borrow
);
    logic [DW-1:0] lhs;

    // Pick the left-hand side and subtract by inverted-operand addition.
    always_comb begin
        if (use_ax)     lhs = acc & xreg;
        else if (use_x) lhs = xreg;
        else            lhs = acc;
        {no_borrow, diff} = {1'b0, lhs} + {1'b0, ~opnd} + {{DW{1'b0}}, 1'b1};
    end
endmodule

// File: rtl/acc_alu.sv
// Module: top of the accumulator ALU. Routes the operation to the logic,
// adder or compare unit and registers result, X result and flags.
// Assumes the sequencer routes A (shift) or Y (compare) onto the ports.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter bit DEC_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [7:0]    acc_i,
    input  logic [7:0]    xreg_i,
    input  logic [7:0]    opnd_i,
    input  logic          c_i,
    input  logic          v_i,
    input  logic          d_i,
    output logic [7:0]    res_o,
    output logic [7:0]    xres_o,
    output logic          n_o,
    output logic          v_o,
    output logic          z_o,
    output logic          c_o
);
    op_e           op;
    flags_t        bit_o, add_o, nxt;
    logic [DW-1:0] cmp_diff, x_nxt;
    logic          cmp_c;

    assign op = op_e'(op_i);

    alu_bitops u_bitops (
        .op   (op),
        .acc  (acc_i),
        .opnd (opnd_i),
        .c_in (c_i),
        .v_in (v_i),
        .o    (bit_o)
    );

    alu_adder #(.DEC_EN(DEC_EN)) u_adder (
        .sub  (op == OP_SBC),
        .acc  (acc_i),
        .opnd (opnd_i),
        .c_in (c_i),
        .d_in (d_i),
        .o    (add_o)
    );

    alu_compare u_compare (
        .use_x     (op == OP_CPX),
        .use_ax    (op == OP_AXS),
        .acc       (acc_i),
        .xreg      (xreg_i),
        .opnd      (opnd_i),
        .diff      (cmp_diff),
        .no_borrow (cmp_c)
    );

    // Merge unit outputs into the next register value.
    always_comb begin
        x_nxt = xreg_i;
        case (op)
            OP_ADC, OP_SBC: nxt = add_o;
            OP_CMP, OP_CPX: nxt = '{res: acc_i, n: cmp_diff[DW-1], v: v_i,
                                    z: (cmp_diff == '0), c: cmp_c};
            OP_AXS: begin
                nxt   = '{res: acc_i, n: cmp_diff[DW-1], v: v_i,
                          z: (cmp_diff == '0), c: cmp_c};
                x_nxt = cmp_diff;
            end
            default: nxt = bit_o;
        endcase
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            xres_o <= '0;
            n_o    <= 1'b0;
            v_o    <= 1'b0;
            z_o    <= 1'b0;
            c_o    <= 1'b0;
        end else begin
            res_o  <= nxt.res;
            xres_o <= x_nxt;
            n_o    <= nxt.n;
            v_o    <= nxt.v;
            z_o    <= nxt.z;
            c_o    <= nxt.c;
        end
    end
endmodule

// File: rtl/acc_alu_checker.sv
// Module: property checker for acc_alu, attached by bind. Relates the
// inputs of one cycle to the registered outputs of the next.
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] xreg_i,
    input logic [7:0] opnd_i,
    input logic       v_i,
    input logic [7:0] res_o,
    input logic [7:0] xres_o,
    input logic       n_o,
    input logic       v_o,
    input logic       z_o
);
    logic keeps_acc, keeps_v, nz_from_res;

    assign keeps_acc   = (op_i == OP_CMP) || (op_i == OP_CPX) || (op_i == OP_BIT) || (op_i == OP_AXS);
    assign keeps_v     = (op_i != OP_ADC) && (op_i != OP_SBC) && (op_i != OP_BIT);
    assign nz_from_res = (op_i <= OP_EOR) || (op_i == OP_PASS) || (op_i == OP_ANC) ||
                         (op_i == OP_ALR) || ((op_i >= OP_ASL) && (op_i <= OP_ROR));

    AST_ACC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        keeps_acc |=> res_o == $past(acc_i)); // R6
    AST_X_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_AXS) |=> xres_o == $past(xreg_i)); // R11
    AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        keeps_v |=> v_o == $past(v_i)); // R10
    AST_NZ_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
        nz_from_res |=> (n_o == res_o[7]) && (z_o == (res_o == 8'h00))); // R7
    AST_BIT_NV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BIT) |=> (n_o == $past(opnd_i[7])) && (v_o == $past(opnd_i[6]))); // R8
endmodule

bind acc_alu acc_alu_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .acc_i  (acc_i),
    .xreg_i (xreg_i),
    .opnd_i (opnd_i),
    .v_i    (v_i),
    .res_o  (res_o),
    .xres_o (xres_o),
    .n_o    (n_o),
    .v_o    (v_o),
    .z_o    (z_o)
);

// File: tb/tb_acc_alu.sv
// Bench: vector table walked by one loop, then directed reset, latency and
// decimal-disable checks. Inputs change on the falling edge.
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc = 8'h00, xr = 8'h00, opnd = 8'h00;
    logic       c_in = 1'b0, v_in = 1'b0, d_in = 1'b0;
    logic [7:0] res, xres, res_b, xres_b;
    logic       n, v, z, c, n_b, v_b, z_b, c_b;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    acc_alu dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .xreg_i(xr), .opnd_i(opnd),
        .c_i(c_in), .v_i(v_in), .d_i(d_in),
        .res_o(res), .xres_o(xres), .n_o(n), .v_o(v), .z_o(z), .c_o(c)
    );

    acc_alu #(.DEC_EN(1'b0)) dut_bin (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .xreg_i(xr), .opnd_i(opnd),
        .c_i(c_in), .v_i(v_in), .d_i(d_in),
        .res_o(res_b), .xres_o(xres_b), .n_o(n_b), .v_o(v_b), .z_o(z_b), .c_o(c_b)
    );

    // Fields: req, op, acc, x, opnd, {c,v,d}, res, x result, {n,v,z,c}
    localparam int NV = 38;
    localparam logic [54:0] VEC [NV] = '{
        {4'd1, 4'd0, 8'h0F,8'h5A,8'hF0,3'b111, 8'hFF,8'h5A,4'b1101}, // R1 ORA, D ignored
        {4'd1, 4'd1, 8'h0F,8'h11,8'hF0,3'b001, 8'h00,8'h11,4'b0010}, // R1 AND
        {4'd1, 4'd2, 8'hAA,8'h5A,8'hFF,3'b100, 8'h55,8'h5A,4'b0001}, // R1 EOR
        {4'd1, 4'd15,8'h12,8'h5A,8'h80,3'b010, 8'h80,8'h5A,4'b1100}, // R1 PASS
        {4'd2, 4'd3, 8'h50,8'h5A,8'h50,3'b000, 8'hA0,8'h5A,4'b1100}, // R2 signed overflow
        {4'd2, 4'd3, 8'hFF,8'h5A,8'h01,3'b000, 8'h00,8'h5A,4'b0011}, // R2 carry out
        {4'd2, 4'd3, 8'h01,8'h5A,8'h01,3'b100, 8'h03,8'h5A,4'b0000}, // R2 carry in
        {4'd2, 4'd4, 8'h50,8'h5A,8'hB0,3'b100, 8'hA0,8'h5A,4'b1100}, // R2 SBC overflow, borrow
        {4'd2, 4'd4, 8'h05,8'h5A,8'h03,3'b000, 8'h01,8'h5A,4'b0001}, // R2 SBC with borrow in
        {4'd2, 4'd4, 8'h00,8'h5A,8'h00,3'b100, 8'h00,8'h5A,4'b0011}, // R2 SBC zero
        {4'd3, 4'd3, 8'h00,8'h5A,8'h0F,3'b001, 8'h15,8'h5A,4'b0000}, // R3 non-BCD digit
        {4'd3, 4'd3, 8'h05,8'h5A,8'h1F,3'b001, 8'h2A,8'h5A,4'b0000}, // R3
        {4'd3, 4'd3, 8'h0F,8'h5A,8'h0A,3'b001, 8'h1F,8'h5A,4'b0000}, // R3
        {4'd3, 4'd3, 8'h0F,8'h5A,8'h0B,3'b001, 8'h10,8'h5A,4'b0000}, // R3
        {4'd3, 4'd3, 8'h12,8'h5A,8'h34,3'b101, 8'h47,8'h5A,4'b0000}, // R3 valid BCD
        {4'd4, 4'd3, 8'h80,8'h5A,8'h80,3'b001, 8'h60,8'h5A,4'b0111}, // R4 Z from binary
        {4'd4, 4'd3, 8'h99,8'h5A,8'h01,3'b001, 8'h00,8'h5A,4'b1001}, // R4 N intermediate
        {4'd4, 4'd3, 8'h58,8'h5A,8'h46,3'b101, 8'h05,8'h5A,4'b1101}, // R4 V intermediate
        {4'd5, 4'd4, 8'h00,8'h5A,8'h01,3'b101, 8'h99,8'h5A,4'b1000}, // R5 wrap
        {4'd5, 4'd4, 8'h10,8'h5A,8'h01,3'b101, 8'h09,8'h5A,4'b0001}, // R5 nibble borrow
        {4'd5, 4'd4, 8'h46,8'h5A,8'h12,3'b101, 8'h34,8'h5A,4'b0001}, // R5 plain
        {4'd5, 4'd4, 8'h32,8'h5A,8'h02,3'b001, 8'h29,8'h5A,4'b0001}, // R5 borrow in
        {4'd6, 4'd5, 8'h40,8'h5A,8'h40,3'b010, 8'h40,8'h5A,4'b0111}, // R6 equal
        {4'd6, 4'd5, 8'h10,8'h5A,8'h20,3'b100, 8'h10,8'h5A,4'b1000}, // R6 less
        {4'd6, 4'd6, 8'h77,8'h30,8'h20,3'b000, 8'h77,8'h30,4'b0001}, // R6 CPX
        {4'd7, 4'd7, 8'h00,8'h5A,8'h81,3'b100, 8'h02,8'h5A,4'b0001}, // R7 ASL
        {4'd7, 4'd8, 8'h00,8'h5A,8'h01,3'b100, 8'h00,8'h5A,4'b0011}, // R7 LSR shifts in 0
        {4'd7, 4'd9, 8'h00,8'h5A,8'h40,3'b100, 8'h81,8'h5A,4'b1000}, // R7 ROL
        {4'd7, 4'd10,8'h00,8'h5A,8'h01,3'b100, 8'h80,8'h5A,4'b1001}, // R7 ROR
        {4'd7, 4'd10,8'h00,8'h5A,8'h02,3'b000, 8'h01,8'h5A,4'b0000}, // R7 ROR carry 0
        {4'd8, 4'd11,8'h0F,8'h5A,8'hC0,3'b100, 8'h0F,8'h5A,4'b1111}, // R8
        {4'd8, 4'd11,8'h01,8'h5A,8'h01,3'b010, 8'h01,8'h5A,4'b0000}, // R8
        {4'd9, 4'd12,8'hF0,8'h5A,8'h8F,3'b010, 8'h80,8'h5A,4'b1101}, // R9 ANC
        {4'd9, 4'd12,8'h7F,8'h5A,8'hFF,3'b100, 8'h7F,8'h5A,4'b0000}, // R9 ANC
        {4'd9, 4'd13,8'hFF,8'h5A,8'h03,3'b000, 8'h01,8'h5A,4'b0001}, // R9 ALR
        {4'd9, 4'd13,8'h02,8'h5A,8'h02,3'b100, 8'h01,8'h5A,4'b0000}, // R9 ALR
        {4'd10,4'd14,8'hF0,8'h3C,8'h10,3'b010, 8'hF0,8'h20,4'b0101}, // R10 AXS
        {4'd10,4'd14,8'hFF,8'h05,8'h06,3'b100, 8'hFF,8'hFF,4'b1000}  // R10 borrow, C in ignored
    };

    task automatic check(input int req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] x,
                         input logic [7:0] b, input logic ci, input logic vi, input logic di);
        op = o; acc = a; xr = x; opnd = b; c_in = ci; v_in = vi; d_in = di;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(12, {res, xres, n, v, z, c}, 20'h0); // R12 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][50:47], VEC[i][46:39], VEC[i][38:31], VEC[i][30:23],
                  VEC[i][22], VEC[i][21], VEC[i][20]);
            @(negedge clk);
            check(int'(VEC[i][54:51]), {res, xres, n, v, z, c}, VEC[i][19:0]);
        end

        // R10: AXS zero result with carry in clear
        drive(4'd14, 8'h0F, 8'h0F, 8'h0F, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(10, {res, xres, n, v, z, c}, {8'h0F, 8'h00, 4'b0011});

        // R12: new inputs not visible before the edge
        drive(4'd0, 8'hC3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        #2;
        check(12, {res, xres, n, v, z, c}, {8'h0F, 8'h00, 4'b0011});
        @(negedge clk);
        check(12, {res, xres, n, v, z, c}, {8'hC3, 8'h00, 4'b1000});

        // R12: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(12, {res, xres, n, v, z, c}, 20'h0);
        rst_n = 1'b1;

        // R13: decimal flag inert when the decimal path is absent
        drive(4'd3, 8'h80, 8'h00, 8'h80, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check(13, {res_b, xres_b, n_b, v_b, z_b, c_b}, {8'h00, 8'h00, 4'b0111});
        check(4, {res, xres, n, v, z, c}, {8'h60, 8'h00, 4'b0111}); // R4 same stimulus
        drive(4'd4, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(13, {res_b, xres_b, n_b, v_b, z_b, c_b}, {8'hFF, 8'h00, 4'b1000});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule